// File: doc/BRIEF.md
# Chip-Select Area Decoder

This block turns a 24-bit bus address into at most one of six chip-select outputs. Two areas sit at fixed windows low in the address map. The other four areas are programmable. Each has an 8-bit base that is compared against the top address byte, and a 3-bit size code that removes low-order base bits from the compare. This gives windows from 64 KB up to 8 MB. Each area also has its own enable, a data-only restriction that makes it ignore instruction fetches, a pin output enable and a pin polarity.

The bus sequencer presents a request with its address and a fetch flag. One clock later the decoder returns the one-hot winning area, its number for per-area timing lookup, a hit flag, and a miss flag when nothing claims the address. All configuration values are static inputs held by the surrounding register block.

Top module: `cs_area_decoder`

## Requirements
- R1: Outputs are registered. A request sampled on a rising edge is reflected after that edge. A cycle with `req_valid` low produces no selection and no miss. Reset clears the selection, hit and miss.
- R2: Area 0 claims exactly the addresses 0x0000F0 through 0x0000FF.
- R3: Area 1 claims addresses from 0x00C000 up to and including `area1_top`.
- R4: A programmable area with size code n (0 to 7, giving 64 KB, 128 KB, 256 KB, 512 KB, 1 MB, 2 MB, 4 MB, 8 MB) claims an address when base bits [7:n] equal address bits [23:16+n]. Programmable area k+2 takes its base from `prog_base[8k+7:8k]` and its size from `prog_size[3k+2:3k]`.
- R5: Area 2 never claims an address below 0x100000, whatever its base and size.
- R6: An area whose `area_en` bit is 0 is never selected.
- R7: An area whose `area_data_only` bit is 1 ignores requests with `req_fetch` high. Such a request may still be claimed by another area.
- R8: When several qualified areas match, the lowest-numbered one wins, so at most one `area_sel` bit is set.
- R9: `no_match` is 1 exactly when a valid request was claimed by no area. It is never 1 together with `area_hit`.
- R10: `area_hit` is 1 when any area was selected, and `area_idx` then holds the winning area number (0 to 5). When nothing is selected, `area_idx` is 0.
- R11: `cs_pin[i]` is 0 when `area_cs_oe[i]` is 0. Otherwise the pin carries the selection active-high when `area_cs_level[i]` is 1, and active-low when it is 0.
- R12: With the default programmable settings (bases 0x00, 0x40, 0x80, 0xC0, all size code 6), areas 2 to 5 split the map into 4 MB quadrants. Area 2 starts at 0x100000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Address request present this cycle |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_addr | input | 24 | Bus address |
| area_en | input | 6 | Per-area decode enable |
| area_data_only | input | 6 | Per-area fetch refusal |
| area_cs_oe | input | 6 | Per-area pin output enable |
| area_cs_level | input | 6 | Per-area pin polarity (1 = active high) |
| prog_base | input | 32 | Bases of areas 2 to 5, one byte each |
| prog_size | input | 12 | Size codes of areas 2 to 5, three bits each |
| area1_top | input | 24 | Inclusive upper address of area 1 |
| area_sel | output | 6 | One-hot winning area |
| area_idx | output | 3 | Number of winning area |
| area_hit | output | 1 | Some area was selected |
| no_match | output | 1 | Valid request claimed by no area |
| cs_pin | output | 6 | Chip-select pin levels after polarity |

## Verification
On every cycle, the bound assertions check the following. The selection is at most one-hot. Hit and miss never coincide, and a valid request always resolves to one of them, while an idle cycle resolves to neither. A selected area was enabled and was not refusing a fetch. The index agrees with the selection, and a request in area 0's window selects area 0 when that area is qualified. The window arithmetic cannot be shown by those properties, so it is left to the bench scenarios. These cover the size-code compare at each of the eight codes, the area 1 upper limit, the area 2 floor, priority between overlapping windows, the default quadrant map and pin polarity under mixed enables.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    localparam int CSD_ADDR_W = 24;
    localparam int CSD_BASE_W = 8;
    localparam int CSD_SZ_W   = 3;
    localparam int CSD_N_PROG = 4;

    // fixed window limits
    localparam logic [CSD_ADDR_W-1:0] CSD_AREA0_LO   = 24'h0000F0;
    localparam logic [CSD_ADDR_W-1:0] CSD_AREA0_HI   = 24'h0000FF;
    localparam logic [CSD_ADDR_W-1:0] CSD_AREA1_LO   = 24'h00C000;
    // the first programmable area never reaches below this address
    localparam logic [CSD_ADDR_W-1:0] CSD_AREA2_FLOOR = 24'h100000;

    // defaults a configuration block loads into the programmable areas
    localparam logic [CSD_N_PROG*CSD_BASE_W-1:0] CSD_DEF_BASES = 32'hC080_4000;
    localparam logic [CSD_SZ_W-1:0]              CSD_DEF_SIZE  = 3'd6;

endpackage

// File: rtl/cs_window_match.sv
module cs_window_match #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit
);
    // inclusive range compare
    assign hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/cs_prog_match.sv
module cs_prog_match #(
    parameter int              ADDR_W    = 24,
    parameter int              BASE_W    = 8,
    parameter int              SZ_W      = 3,
    parameter bit              USE_FLOOR = 1'b0,
    parameter logic [ADDR_W-1:0] FLOOR   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic [SZ_W-1:0]   size,
    output logic              hit
);
    localparam int LSB = ADDR_W - BASE_W;

    logic [BASE_W-1:0] mask;
    logic [BASE_W-1:0] diff;
    logic              above;

    always_comb begin
        // size code n drops the n lowest base bits from the compare
        mask = {BASE_W{1'b1}} << size;
        diff = (addr[ADDR_W-1:LSB] ^ base) & mask;
    end

    generate
        if (USE_FLOOR) begin : g_floor
            assign above = (addr >= FLOOR);
        end else begin : g_nofloor
            assign above = 1'b1;
        end
    endgenerate

    assign hit = (diff == '0) && above;
endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
    parameter int N    = 6,
    parameter int IW   = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        // scan from the top so the lowest requester is written last
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cs_area_decoder.sv
module cs_area_decoder
    import cs_dec_pkg::*;
#(
    parameter int ADDR_W = CSD_ADDR_W,
    parameter int BASE_W = CSD_BASE_W,
    parameter int SZ_W   = CSD_SZ_W,
    parameter int N_PROG = CSD_N_PROG,
    parameter int N_AREA = N_PROG + 2,
    parameter int IDX_W  = $clog2(N_PROG + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_fetch,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [N_AREA-1:0]        area_en,
    input  logic [N_AREA-1:0]        area_data_only,
    input  logic [N_AREA-1:0]        area_cs_oe,
    input  logic [N_AREA-1:0]        area_cs_level,
    input  logic [N_PROG*BASE_W-1:0] prog_base,
    input  logic [N_PROG*SZ_W-1:0]   prog_size,
    input  logic [ADDR_W-1:0]        area1_top,
    output logic [N_AREA-1:0]        area_sel,
    output logic [IDX_W-1:0]         area_idx,
    output logic                     area_hit,
    output logic                     no_match,
    output logic [N_AREA-1:0]        cs_pin
);

    typedef struct packed {
        logic [N_AREA-1:0] sel;
        logic [IDX_W-1:0]  idx;
        logic              hit;
        logic              miss;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic [N_AREA-1:0] raw_hit;
    logic [N_AREA-1:0] qual_hit;
    logic [N_AREA-1:0] grant;
    logic [IDX_W-1:0]  win_idx;
    logic              win_any;

    // fixed windows
    cs_window_match #(.ADDR_W(ADDR_W)) u_area0 (
        .addr (req_addr),
        .lo   (ADDR_W'(CSD_AREA0_LO)),
        .hi   (ADDR_W'(CSD_AREA0_HI)),
        .hit  (raw_hit[0])
    );

    cs_window_match #(.ADDR_W(ADDR_W)) u_area1 (
        .addr (req_addr),
        .lo   (ADDR_W'(CSD_AREA1_LO)),
        .hi   (area1_top),
        .hit  (raw_hit[1])
    );

    // programmable windows; only the first one carries the floor
    generate
        for (genvar k = 0; k < N_PROG; k++) begin : g_prog
            cs_prog_match #(
                .ADDR_W    (ADDR_W),
                .BASE_W    (BASE_W),
                .SZ_W      (SZ_W),
                .USE_FLOOR (k == 0),
                .FLOOR     (ADDR_W'(CSD_AREA2_FLOOR))
            ) u_match (
                .addr (req_addr),
                .base (prog_base[k*BASE_W +: BASE_W]),
                .size (prog_size[k*SZ_W +: SZ_W]),
                .hit  (raw_hit[k+2])
            );
        end
    endgenerate

    cs_prio_pick #(.N(N_AREA), .IW(IDX_W)) u_pick (
        .req   (qual_hit),
        .grant (grant),
        .idx   (win_idx),
        .any   (win_any)
    );

    always_comb begin
        qual_hit = raw_hit
                 & area_en
                 & ~(area_data_only & {N_AREA{req_fetch}})
                 & {N_AREA{req_valid}};
        st_d      = '0;
        st_d.sel  = grant;
        st_d.idx  = win_idx;
        st_d.hit  = win_any;
        st_d.miss = req_valid & ~win_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign area_sel = st_q.sel;
    assign area_idx = st_q.idx;
    assign area_hit = st_q.hit;
    assign no_match = st_q.miss;

    // polarity and output enable per pin
    generate
        for (genvar i = 0; i < N_AREA; i++) begin : g_pin
            assign cs_pin[i] = area_cs_oe[i] & ~(st_q.sel[i] ^ area_cs_level[i]);
        end
    endgenerate

endmodule

// File: rtl/cs_area_decoder_chk.sv
module cs_area_decoder_chk #(
    parameter int ADDR_W = 24,
    parameter int N_AREA = 6,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_fetch,
    input logic [ADDR_W-1:0] req_addr,
    input logic [N_AREA-1:0] area_en,
    input logic [N_AREA-1:0] area_data_only,
    input logic [N_AREA-1:0] area_sel,
    input logic [IDX_W-1:0]  area_idx,
    input logic              area_hit,
    input logic              no_match
);

    assert_onehot_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(area_sel));

    assert_hit_miss_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(area_hit && no_match));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!area_hit && !no_match && area_sel == '0));

    assert_valid_resolves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid)) |-> (area_hit || no_match));

    assert_idx_agrees_R10: assert property (@(posedge clk) disable iff (!rst_n)
        area_hit |-> (area_sel == (N_AREA'(1) << area_idx)));

    assert_area0_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(area_en[0])
         && !($past(req_fetch) && $past(area_data_only[0]))
         && $past(req_addr) >= ADDR_W'(24'h0000F0)
         && $past(req_addr) <= ADDR_W'(24'h0000FF)) |-> area_sel[0]);

    generate
        for (genvar k = 0; k < N_AREA; k++) begin : g_area
            assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
                area_sel[k] |-> $past(area_en[k]));

            assert_fetch_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
                area_sel[k] |-> !($past(req_fetch) && $past(area_data_only[k])));
        end
    endgenerate

endmodule

bind cs_area_decoder cs_area_decoder_chk #(
    .ADDR_W (ADDR_W),
    .N_AREA (N_AREA),
    .IDX_W  (IDX_W)
) i_chk (.*);

// File: tb/test_cs_area_decoder.sv
`timescale 1ns/1ps
module test_cs_area_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_fetch = 1'b0;
    logic [23:0] req_addr = '0;
    logic [5:0]  area_en, area_data_only, area_cs_oe, area_cs_level;
    logic [31:0] prog_base;
    logic [11:0] prog_size;
    logic [23:0] area1_top;
    logic [5:0]  area_sel;
    logic [2:0]  area_idx;
    logic        area_hit, no_match;
    logic [5:0]  cs_pin;

    // pending configuration, applied at the next driven cycle
    logic [5:0]  n_en, n_donly, n_oe, n_lvl;
    logic [31:0] n_base;
    logic [11:0] n_size;
    logic [23:0] n_top;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] sel;
        logic [2:0] idx;
        logic       hit;
        logic       miss;
        logic [5:0] pin;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    cs_area_decoder i_cs_area_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
        .req_addr(req_addr), .area_en(area_en), .area_data_only(area_data_only),
        .area_cs_oe(area_cs_oe), .area_cs_level(area_cs_level),
        .prog_base(prog_base), .prog_size(prog_size), .area1_top(area1_top),
        .area_sel(area_sel), .area_idx(area_idx), .area_hit(area_hit),
        .no_match(no_match), .cs_pin(cs_pin)
    );

    // expectation from the requirements
    function automatic exp_t model(input logic v, input logic f, input logic [23:0] a,
                                   input string tag);
        exp_t e;
        logic [5:0] m;
        e.sel = '0; e.idx = '0; e.hit = 1'b0; e.miss = 1'b0; e.tag = tag;
        m[0] = (a >= 24'h0000F0) && (a <= 24'h0000FF);
        m[1] = (a >= 24'h00C000) && (a <= area1_top);
        for (int k = 0; k < 4; k++) begin
            int n;
            logic [7:0] b;
            n = int'(prog_size[k*3 +: 3]);
            b = prog_base[k*8 +: 8];
            m[k+2] = ((a[23:16] >> n) == (b >> n));
        end
        if (a < 24'h100000) m[2] = 1'b0;
        if (v) begin
            for (int i = 0; i < 6; i++) begin
                if (!e.hit && m[i] && area_en[i] && !(f && area_data_only[i])) begin
                    e.hit = 1'b1; e.sel[i] = 1'b1; e.idx = 3'(i);
                end
            end
            e.miss = !e.hit;
        end
        for (int i = 0; i < 6; i++)
            e.pin[i] = area_cs_oe[i] ? (area_cs_level[i] ? e.sel[i] : !e.sel[i]) : 1'b0;
        return e;
    endfunction

    task automatic cyc(input logic v, input logic f, input logic [23:0] a, input string tag);
        @(negedge clk);
        area_en = n_en; area_data_only = n_donly; area_cs_oe = n_oe; area_cs_level = n_lvl;
        prog_base = n_base; prog_size = n_size; area1_top = n_top;
        req_valid = v; req_fetch = f; req_addr = a;
        q.push_back(model(v, f, a, tag));
    endtask

    // monitor: compare just after the edge that registered the request
    always @(posedge clk) begin
        #1;
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (area_sel !== e.sel || area_idx !== e.idx || area_hit !== e.hit ||
                no_match !== e.miss || cs_pin !== e.pin) begin
                errors++;
                $display("FAIL %s: got sel=%b idx=%0d hit=%b miss=%b pin=%b exp sel=%b idx=%0d hit=%b miss=%b pin=%b",
                         e.tag, area_sel, area_idx, area_hit, no_match, cs_pin,
                         e.sel, e.idx, e.hit, e.miss, e.pin);
            end
        end
    end

    task automatic set_defaults();
        n_en = 6'b111111; n_donly = '0; n_oe = 6'b111111; n_lvl = '0;
        n_base = 32'hC080_4000; n_size = {4{3'd6}}; n_top = 24'h00FFDE;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got running exp finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        set_defaults();
        area_en = n_en; area_data_only = n_donly; area_cs_oe = n_oe; area_cs_level = n_lvl;
        prog_base = n_base; prog_size = n_size; area1_top = n_top;
        repeat (3) @(negedge clk);
        // R1: reset state, all pins idle at active-low inactive level
        checks++;
        if (area_sel !== 6'b0 || area_hit !== 1'b0 || no_match !== 1'b0 || cs_pin !== 6'b111111) begin
            errors++;
            $display("FAIL R1 reset: got sel=%b hit=%b miss=%b pin=%b exp sel=000000 hit=0 miss=0 pin=111111",
                     area_sel, area_hit, no_match, cs_pin);
        end
        rst_n = 1'b1;

        cyc(1'b0, 1'b0, 24'h0000F5, "R1 idle");
        cyc(1'b1, 1'b0, 24'h0000F5, "R2 area0 inside");
        cyc(1'b1, 1'b0, 24'h0000F0, "R2 area0 low edge");
        cyc(1'b1, 1'b0, 24'h0000EF, "R9 below area0");
        cyc(1'b1, 1'b0, 24'h000100, "R2 above area0");
        cyc(1'b1, 1'b0, 24'h00C000, "R3 area1 start");
        cyc(1'b1, 1'b0, 24'h00FFDE, "R3 area1 top");
        cyc(1'b1, 1'b0, 24'h00FFDF, "R5 past area1 top");
        cyc(1'b1, 1'b0, 24'h0FFFFF, "R5 below floor");
        cyc(1'b1, 1'b0, 24'h100000, "R5 floor start R12");
        cyc(1'b1, 1'b0, 24'h3FFFFF, "R12 area2 end");
        cyc(1'b1, 1'b0, 24'h400000, "R12 area3");
        cyc(1'b1, 1'b0, 24'h8ABCDE, "R12 area4");
        cyc(1'b1, 1'b0, 24'hFFFFFF, "R12 area5 R10");

        // R4: each size code, one address inside and one just outside
        n_en = 6'b001000;
        n_base[15:8] = 8'h5A;
        for (int n = 0; n < 8; n++) begin
            logic [7:0] inb, outb;
            n_size[5:3] = 3'(n);
            inb  = 8'h5A ^ 8'((9'd1 << n) - 9'd1);
            outb = 8'h5A ^ 8'(9'd1 << n);
            cyc(1'b1, 1'b0, {inb, 16'h1234}, "R4 inside");
            cyc(1'b1, 1'b0, {outb, 16'h1234}, "R4 outside");
        end

        // R6: disable the matching area
        set_defaults();
        n_en = 6'b110111;
        cyc(1'b1, 1'b0, 24'h456789, "R6 disabled area3");
        n_en = 6'b111110;
        cyc(1'b1, 1'b0, 24'h0000F8, "R6 disabled area0");

        // R7 and R8: data-only area4 overlapped by area5
        set_defaults();
        n_base[31:24] = 8'h80;
        n_donly = 6'b010000;
        cyc(1'b1, 1'b1, 24'h812345, "R7 fetch falls to area5");
        cyc(1'b1, 1'b0, 24'h812345, "R8 read area4 wins");
        n_en = 6'b011111;
        cyc(1'b1, 1'b1, 24'h812345, "R7 fetch refused miss");

        // R8: area2 widened over area3
        set_defaults();
        n_size[2:0] = 3'd7;
        cyc(1'b1, 1'b0, 24'h456789, "R8 area2 over area3");
        cyc(1'b1, 1'b1, 24'h456789, "R8 fetch area2");

        // R11: mixed polarity and output enables
        set_defaults();
        n_lvl = 6'b101010; n_oe = 6'b110111;
        cyc(1'b1, 1'b0, 24'h456789, "R11 area3 oe off");
        cyc(1'b1, 1'b0, 24'h912345, "R11 area4 low");
        cyc(1'b1, 1'b0, 24'hC00001, "R11 area5 high");
        cyc(1'b1, 1'b0, 24'h00C123, "R11 area1 high");
        cyc(1'b0, 1'b0, 24'h00C123, "R11 R1 idle pins");

        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule